// File: doc/BRIEF.md
# Iterative Bitsliced SPN Block Encryptor

This core encrypts one 128-bit block with a 32-round substitution-permutation cipher, working through one round per clock cycle. The block is held as four 32-bit words. Each round mixes in a 128-bit round key, passes the state through one of eight 4-bit substitution boxes applied bitsliced across all 32 bit positions, and then runs a rotate/shift/XOR mixing network over the four words. The last round drops the mixing network and instead applies a 33rd round key.

Round keys are not generated here. They sit in an external synchronous memory of 33 entries, 128 bits each, that the core addresses itself. The address is issued one cycle before the key is needed, so a memory with a registered read port fits directly. A host pulses start with the plaintext on the input, watches busy, and takes the ciphertext when done pulses.

Top module: `spn_enc_core`

## Requirements
- R1: While reset is asserted, busy_o and done_o are 0, ct_o is all zeros and key_addr_o is 0.
- R2: A start_i pulse sampled while idle loads pt_i and raises busy_o on the next cycle with the round count at 0. While idle, key_addr_o is 0.
- R3: busy_o stays high for exactly 33 cycles (32 rounds plus one final key cycle). done_o is high for exactly the one cycle after busy_o falls and is never high together with busy_o.
- R4: In the n-th busy cycle (n = 1..33), key_addr_o equals n, capped at 32. Key data returned one cycle after an address is the key used in that cycle.
- R5: Round r (0..31) XORs round key r into the state and then applies S-box number r mod 8. Rounds 0..30 then apply the linear mixing network. In that network x0 and x2 rotate left by 13 and 3. Then x1 ^= x0^x2 and x3 ^= x2^(x0<<3). Next x1 and x3 rotate left by 1 and 7, x0 ^= x1^x3 and x2 ^= x3^(x1<<7). Last, x0 and x2 rotate left by 5 and 22.
- R6: Word packing: x0..x3 are bits [31:0], [63:32], [95:64] and [127:96] of pt_i, of ct_o and of every key word group. The S-box input nibble at bit position i is {x3[i],x2[i],x1[i],x0[i]}, with x0 as the least significant bit. The output nibble is written back in the same order.
- R7: After round 31, round key 32 is XORed into the state and the result appears on ct_o together with the done_o pulse.
- R8: A start_i pulse sampled while busy_o is high is ignored. The running encryption continues unchanged and returns the result for the original plaintext.
- R9: ct_o changes only in the cycle where done_o is high. Changing pt_i while idle without a start has no effect on ct_o or busy_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin encrypting pt_i (honoured only while idle) |
| pt_i | input | 128 | Plaintext block |
| key_i | input | 128 | Round key returned by the key memory |
| key_addr_o | output | 6 | Round key index requested from the key memory |
| busy_o | output | 1 | Encryption in progress |
| done_o | output | 1 | One-cycle pulse: ct_o holds a fresh result |
| ct_o | output | 128 | Ciphertext block |

## Verification
The bench builds the core with its default of 32 rounds. That default is the only setting where all eight S-boxes are used four times each and round 31 is the one that skips the mixing step, so the full 33-key schedule and the capped last address can be observed. With all-zero, all-ones and patterned key memories, every S-box sees both constant and varied nibbles. The cycle-by-cycle address check confirms the one-cycle lead of the key fetch against a registered memory model.

// File: rtl/spn_pkg.sv
package spn_pkg;

   localparam int WORD_W = 32;
   localparam int NWORDS = 4;
   localparam int NBOXES = 8;

   typedef logic [NWORDS-1:0][WORD_W-1:0] blk_t;

   // Entry v of box s sits at SBOX_TBL[s][4*v +: 4]
   localparam logic [NBOXES-1:0][63:0] SBOX_TBL = '{
      64'h6539AC47B28E0FD1,
      64'h0A3DF19EB6485C27,
      64'h16D8E370C9A4B25F,
      64'hD7E9A4526B0C38F1,
      64'hE57A421D369C8BF0,
      64'h25B04E1DFAC39768,
      64'h43D68EB1A50972CF,
      64'hC90724DEB56A1F83
   };

   function automatic logic [3:0] sbox_nib(input logic [2:0] sel, input logic [3:0] nib);
      logic [63:0] row;
      row = SBOX_TBL[sel];
      return row[{nib, 2'b00} +: 4];
   endfunction

   function automatic logic [WORD_W-1:0] rotl(input logic [WORD_W-1:0] v, input int unsigned n);
      return (v << n) | (v >> (WORD_W - n));
   endfunction

endpackage

// File: rtl/spn_sbox_layer.sv
module spn_sbox_layer
   import spn_pkg::*;
(
   input  logic [2:0] sel_i,
   input  blk_t       din_i,
   output blk_t       dout_o
);

   for (genvar b = 0; b < WORD_W; b++) begin : g_slice
      logic [3:0] nib_in;
      logic [3:0] nib_out;
      assign nib_in  = {din_i[3][b], din_i[2][b], din_i[1][b], din_i[0][b]};
      assign nib_out = sbox_nib(sel_i, nib_in);
      for (genvar w = 0; w < NWORDS; w++) begin : g_word
         assign dout_o[w][b] = nib_out[w];
      end
   end

endmodule

// File: rtl/spn_lin_mix.sv
module spn_lin_mix
   import spn_pkg::*;
#(
   parameter int unsigned ROT_A0 = 13,
   parameter int unsigned ROT_A2 = 3,
   parameter int unsigned SHL_A  = 3,
   parameter int unsigned ROT_B1 = 1,
   parameter int unsigned ROT_B3 = 7,
   parameter int unsigned SHL_B  = 7,
   parameter int unsigned ROT_C0 = 5,
   parameter int unsigned ROT_C2 = 22
)(
   input  blk_t din_i,
   output blk_t dout_o
);

   if (ROT_A0 == 0 || ROT_A0 >= WORD_W || ROT_C2 == 0 || ROT_C2 >= WORD_W) begin : g_bad_rot
      $error("spn_lin_mix: rotation amounts must lie in 1..WORD_W-1");
   end

   logic [WORD_W-1:0] a0, a1, a2, a3;
   logic [WORD_W-1:0] b0, b1, b2, b3;

   always_comb begin
      a0 = rotl(din_i[0], ROT_A0);
      a2 = rotl(din_i[2], ROT_A2);
      a1 = din_i[1] ^ a0 ^ a2;
      a3 = din_i[3] ^ a2 ^ (a0 << SHL_A);
      b1 = rotl(a1, ROT_B1);
      b3 = rotl(a3, ROT_B3);
      b0 = a0 ^ b1 ^ b3;
      b2 = a2 ^ b3 ^ (b1 << SHL_B);
      dout_o[0] = rotl(b0, ROT_C0);
      dout_o[1] = b1;
      dout_o[2] = rotl(b2, ROT_C2);
      dout_o[3] = b3;
   end

endmodule

// File: rtl/spn_round_ctl.sv
module spn_round_ctl #(
   parameter  int ROUNDS = 32,
   localparam int CNT_W  = $clog2(ROUNDS + 1)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   output logic             busy_o,
   output logic             done_o,
   output logic [CNT_W-1:0] rnd_o,
   output logic [CNT_W-1:0] key_addr_o
);

   localparam logic [CNT_W-1:0] FIN_IDX = CNT_W'(ROUNDS);

   logic             busy_q, done_q;
   logic [CNT_W-1:0] rnd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         rnd_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (start_i) begin
               busy_q <= 1'b1;
               rnd_q  <= '0;
            end
         end else if (rnd_q == FIN_IDX) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
         end else begin
            rnd_q <= rnd_q + 1'b1;
         end
      end
   end

   // Address leads use by one cycle; it parks on the final key index.
   always_comb begin
      if (!busy_q)                key_addr_o = '0;
      else if (rnd_q == FIN_IDX)  key_addr_o = FIN_IDX;
      else                        key_addr_o = rnd_q + 1'b1;
   end

   assign busy_o = busy_q;
   assign done_o = done_q;
   assign rnd_o  = rnd_q;

   assert_start_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i) |=> (busy_o && rnd_o == '0));

   assert_done_after_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o)));

   assert_addr_advances_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> (key_addr_o == $past(key_addr_o) + 1'b1 || key_addr_o == FIN_IDX));

   assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && rnd_o != FIN_IDX) |=> (busy_o && rnd_o == $past(rnd_o) + 1'b1));

endmodule

// File: rtl/spn_enc_core.sv
module spn_enc_core
   import spn_pkg::*;
#(
   parameter  int ROUNDS = 32,
   localparam int CNT_W  = $clog2(ROUNDS + 1),
   localparam int BLK_W  = WORD_W * NWORDS
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [BLK_W-1:0] pt_i,
   input  logic [BLK_W-1:0] key_i,
   output logic [CNT_W-1:0] key_addr_o,
   output logic             busy_o,
   output logic             done_o,
   output logic [BLK_W-1:0] ct_o
);

   if (ROUNDS < NBOXES || (ROUNDS % NBOXES) != 0) begin : g_bad_rounds
      $error("spn_enc_core: ROUNDS must be a positive multiple of the S-box count");
   end

   localparam logic [CNT_W-1:0] LAST_RND = CNT_W'(ROUNDS - 1);
   localparam logic [CNT_W-1:0] FIN_IDX  = CNT_W'(ROUNDS);

   logic [CNT_W-1:0] rnd;
   logic             busy, done;
   blk_t             st_q, ct_q, key_w, mixed, subbed, linned;

   spn_round_ctl #(.ROUNDS(ROUNDS)) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .busy_o    (busy),
      .done_o    (done),
      .rnd_o     (rnd),
      .key_addr_o(key_addr_o)
   );

   assign key_w = blk_t'(key_i);
   assign mixed = st_q ^ key_w;

   spn_sbox_layer u_sbox (
      .sel_i (rnd[2:0]),
      .din_i (mixed),
      .dout_o(subbed)
   );

   spn_lin_mix u_mix (
      .din_i (subbed),
      .dout_o(linned)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= '0;
         ct_q <= '0;
      end else if (!busy) begin
         if (start_i) st_q <= blk_t'(pt_i);
      end else if (rnd == FIN_IDX) begin
         ct_q <= mixed;
      end else begin
         st_q <= (rnd == LAST_RND) ? subbed : linned;
      end
   end

   assign busy_o = busy;
   assign done_o = done;
   assign ct_o   = ct_q;

   assert_no_busy_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy_o && done_o));

   assert_ct_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(ct_o));

endmodule

// File: tb/sim_spn_enc_core.sv
module sim_spn_enc_core;

   localparam int CLK_P  = 10;
   localparam int ROUNDS = 32;
   localparam int NKEYS  = ROUNDS + 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic [127:0] pt_i = '0;
   logic [127:0] key_q = '0;
   logic [5:0]   key_addr_o;
   logic         busy_o, done_o;
   logic [127:0] ct_o;

   logic [127:0] kmem [NKEYS];

   int total = 0;
   int bad   = 0;

   always #(CLK_P/2) clk = ~clk;

   always_ff @(posedge clk) key_q <= kmem[key_addr_o];

   spn_enc_core #(.ROUNDS(ROUNDS)) u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .pt_i      (pt_i),
      .key_i     (key_q),
      .key_addr_o(key_addr_o),
      .busy_o    (busy_o),
      .done_o    (done_o),
      .ct_o      (ct_o)
   );

   // Natural order: entry 0 in the top nibble
   localparam logic [63:0] SB_NAT [8] = '{
      64'h38F1A65BED42709C, 64'hFC27905A1BE86D34,
      64'h86793CAFD1E40B52, 64'h0FB8C963D124A75E,
      64'h1F83C0B6254A9E7D, 64'hF52B4A9C073E8D61,
      64'h72C5846BE91FD3A0, 64'h1DF0E82B74CA9356
   };

   function automatic logic [31:0] rl(input logic [31:0] v, input int n);
      return (v << n) | (v >> (32 - n));
   endfunction

   function automatic logic [127:0] model_enc(input logic [127:0] p);
      logic [31:0] w [4];
      logic [31:0] t [4];
      logic [3:0]  n, o;
      for (int j = 0; j < 4; j++) w[j] = p[32*j +: 32];
      for (int r = 0; r < ROUNDS; r++) begin
         for (int j = 0; j < 4; j++) w[j] ^= kmem[r][32*j +: 32];
         for (int b = 0; b < 32; b++) begin
            n = {w[3][b], w[2][b], w[1][b], w[0][b]};
            o = SB_NAT[r % 8][60 - 4*n +: 4];
            for (int j = 0; j < 4; j++) t[j][b] = o[j];
         end
         for (int j = 0; j < 4; j++) w[j] = t[j];
         if (r < ROUNDS - 1) begin
            w[0] = rl(w[0], 13);
            w[2] = rl(w[2], 3);
            w[1] = w[1] ^ w[0] ^ w[2];
            w[3] = w[3] ^ w[2] ^ (w[0] << 3);
            w[1] = rl(w[1], 1);
            w[3] = rl(w[3], 7);
            w[0] = w[0] ^ w[1] ^ w[3];
            w[2] = w[2] ^ w[3] ^ (w[1] << 7);
            w[0] = rl(w[0], 5);
            w[2] = rl(w[2], 22);
         end
      end
      for (int j = 0; j < 4; j++) w[j] ^= kmem[ROUNDS][32*j +: 32];
      return {w[3], w[2], w[1], w[0]};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic fill_keys(input int mode);
      for (int k = 0; k < NKEYS; k++) begin
         for (int j = 0; j < 4; j++) begin
            case (mode)
               0:       kmem[k][32*j +: 32] = 32'h0;
               1:       kmem[k][32*j +: 32] = 32'hFFFF_FFFF;
               default: kmem[k][32*j +: 32] = 32'h9E37_79B9 * (4*k + j + 1) ^ (32'(mode) << 7);
            endcase
         end
      end
   endtask

   // Runs one block; poke > 0 raises start with another plaintext in busy cycle poke.
   task automatic run_block(input logic [127:0] p, input int poke, input string tag);
      logic [127:0] exp;
      bit timing_ok = 1'b1;
      bit addr_ok = 1'b1;
      exp = model_enc(p);
      @(negedge clk);
      pt_i = p;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o === 1'b1, {"R2 busy after start ", tag}, 128'(busy_o), 128'd1);
      for (int i = 1; i <= 33; i++) begin
         if (i > 1) @(negedge clk);
         if (i == poke + 1) start_i = 1'b0;
         if (busy_o !== 1'b1 || done_o !== 1'b0) begin
            timing_ok = 1'b0;
            chk(1'b0, {"R3 busy window ", tag}, 128'({busy_o, done_o}), 128'b10);
         end
         if (key_addr_o !== 6'((i < 32) ? i : 32)) begin
            addr_ok = 1'b0;
            chk(1'b0, {"R4 key address ", tag}, 128'(key_addr_o), 128'((i < 32) ? i : 32));
         end
         if (i == poke) begin
            start_i = 1'b1;
            pt_i = ~p;
         end
      end
      chk(timing_ok, {"R3 busy for 33 cycles ", tag}, 128'(timing_ok), 128'd1);
      chk(addr_ok, {"R4 address sequence ", tag}, 128'(addr_ok), 128'd1);
      start_i = 1'b0;
      @(negedge clk);
      chk(done_o === 1'b1 && busy_o === 1'b0, {"R3 done pulse ", tag}, 128'({busy_o, done_o}), 128'b01);
      chk(ct_o === exp, {"R5 R6 R7 ciphertext ", tag}, ct_o, exp);
      @(negedge clk);
      chk(done_o === 1'b0, {"R3 done one cycle ", tag}, 128'(done_o), 128'd0);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(busy_o === 1'b0 && done_o === 1'b0, "R1 reset flags", 128'({busy_o, done_o}), 128'd0);
      chk(ct_o === '0, "R1 reset ciphertext", ct_o, '0);
      chk(key_addr_o === '0, "R1 reset key address", 128'(key_addr_o), 128'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(key_addr_o === '0, "R2 idle key address", 128'(key_addr_o), 128'd0);
   endtask

   task automatic t_zero;
      fill_keys(0);
      run_block('0, 0, "zero key zero data");
   endtask

   task automatic t_ones;
      fill_keys(1);
      run_block('1, 0, "ones key ones data");
      run_block('0, 0, "ones key zero data");
   endtask

   task automatic t_pattern;
      fill_keys(2);
      run_block(128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 0, "pattern A");
      run_block(128'h8000_0000_0000_0000_0000_0000_0000_0001, 0, "pattern B");
      fill_keys(5);
      run_block(128'hDEAD_BEEF_0000_FFFF_A5A5_5A5A_1357_9BDF, 0, "pattern C");
   endtask

   task automatic t_start_ignored;
      fill_keys(3);
      run_block(128'h1111_2222_3333_4444_5555_6666_7777_8888, 7, "R8 start mid-run");
      run_block(128'hCAFE_F00D_0BAD_BEEF_1234_5678_9ABC_DEF0, 32, "R8 start at last key");
   endtask

   task automatic t_hold;
      logic [127:0] held;
      held = ct_o;
      pt_i = ~pt_i;
      repeat (5) @(negedge clk);
      chk(ct_o === held, "R9 ct held while idle", ct_o, held);
      chk(busy_o === 1'b0, "R9 no start means idle", 128'(busy_o), 128'd0);
   endtask

   initial begin
      t_reset();
      t_zero();
      t_ones();
      t_pattern();
      t_start_ignored();
      t_hold();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_P * 200000);
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule